// File: doc/BRIEF.md
# Push-Pull Two-Wire Transfer Engine

This block is the master side of a serial link to a single target over two push-pull wires, a clock line and a data line. Each transaction moves between one and eight data bytes that belong to one 8-bit register address. The target is the only device on the link, so no device address goes on the wire and no acknowledge slot follows any byte. Every byte is followed by an odd parity bit instead. A read takes one access: the address is sent and the target answers inside the same frame.

A host loads the direction, the byte count, the register address, the write bytes, a clock divider and a data output delay, and pulses `start_i`. The engine captures these values and drives the frame: a start condition, the direction bit, the address byte, the data bytes and a stop condition. It then reports completion with a one-cycle `done_o`. In a read, `err_o` also flags a parity mismatch in received data. The data line is driven through an output enable so that the target can drive the line in read slots.

Top module: `p2w_engine`

## Requirements
- R1: After reset, and whenever no transaction is in progress, `scl_o`, `sda_o` and `sda_oe_o` are 1, and `busy_o`, `done_o` and `err_o` are 0. `rdata_o` resets to 0.
- R2: A frame begins with SDA falling while SCL is high and ends with SDA rising while SCL is high. `done_o` is 1 for exactly one cycle, the first cycle after the stop condition, and `busy_o` is 0 in that cycle.
- R3: The first bit of the frame is the direction (1 = read, 0 = write). The next eight bits are the register address, MSB first, followed by one parity bit chosen so that the address bits and the parity bit together contain an odd number of ones. No device address and no acknowledge slot appear.
- R4: `len_i` holds the byte count minus one. In a write, the bytes are sent in order starting with `wdata_i[7:0]`, each MSB first and followed by its odd parity bit. A frame therefore holds 10 + 9 × count bit slots.
- R5: In a read, the engine releases SDA (`sda_oe_o` = 0) for the 9 × count slots that follow the address parity bit. It samples `sda_i` as SCL rises. Received byte k is stored in `rdata_o[8k+7:8k]` and is kept after the frame.
- R6: If any received byte arrives with a parity bit that breaks the odd-parity rule, `err_o` is 1 in the `done_o` cycle. Otherwise `err_o` stays 0.
- R7: Each high phase and each low phase of SCL lasts `div_i` module clocks. Values below 2 are treated as 2.
- R8: Within a frame, the SDA outputs (`sda_o`, `sda_oe_o`) change only while SCL is low. Each change comes exactly D module clocks after SCL falls, where D is `dly_i` raised to at least 1 and limited to at most one less than the phase length. While SCL stays high, SDA holds still, except at the start and stop conditions.
- R9: `busy_o` rises in the cycle after a `start_i` that arrives while idle. The engine captures all transaction inputs at that point. A `start_i` pulse while busy is ignored, and later changes to the inputs have no effect on the frame in progress.
- R10: A `start_i` presented in the same cycle as `done_o` is accepted, so frames can follow one another without an idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that launches a transaction when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| len_i | input | LEN_W (3) | Byte count minus one |
| addr_i | input | 8 | Target register address |
| wdata_i | input | MAX_BYTES×8 (64) | Write bytes, byte 0 in the low bits |
| div_i | input | DIV_W (8) | Module clocks per SCL phase |
| dly_i | input | DLY_W (3) | SDA change delay after SCL falls |
| sda_i | input | 1 | Sampled data line |
| scl_o | output | 1 | Serial clock |
| sda_o | output | 1 | Data line output value |
| sda_oe_o | output | 1 | Data line output enable |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Parity error, valid with `done_o` |
| rdata_o | output | MAX_BYTES×8 (64) | Received bytes, byte 0 in the low bits |

## Verification
The completion pulse and the acceptance of the next transaction can fall in the same cycle. The bench watches for `done_o` and raises `start_i` in that very cycle, which chains a two-byte read into a one-byte write. It then checks that the first frame still completes with a proper stop condition and correct read data, and that `busy_o` is high on the following cycle. It also checks that the second frame carries its own header, data and timing. A second collision, a stray `start_i` in the middle of a write, is judged by comparing every bit on the wire with the originally captured values.

// File: rtl/p2w_pkg.sv
package p2w_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_BIT_LO,
      ST_BIT_HI,
      ST_STOP_LO,
      ST_STOP_HI
   } p2w_state_e;

   // slot counter within one byte: 0..7 data, 8 parity
   localparam int POS_W = 4;
   localparam logic [POS_W-1:0] PAR_POS = 4'd8;

   // bit that makes the nine-bit group hold an odd number of ones
   function automatic logic odd_par(input logic [7:0] b);
      return ~^b;
   endfunction

endpackage

// File: rtl/p2w_halftimer.sv
module p2w_halftimer #(
   parameter int DIV_W = 8,
   parameter int DLY_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   input  logic [DLY_W-1:0] dly,
   output logic             half_end,
   output logic             drv_pt
);
   localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);
   localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);

   logic [DIV_W-1:0] div_eff;
   logic [DIV_W-1:0] dly_eff;
   logic [DIV_W-1:0] cnt;

   always_comb begin
      div_eff = (div < DIV_MIN) ? DIV_MIN : div;
      dly_eff = (dly == '0) ? ONE : DIV_W'(dly);
      if (dly_eff > div_eff - ONE) begin
         dly_eff = div_eff - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || half_end) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + ONE;
      end
   end

   assign half_end = run && (cnt == div_eff - ONE);
   assign drv_pt   = run && (cnt == dly_eff - ONE);

endmodule

// File: rtl/p2w_bitsrc.sv
module p2w_bitsrc
   import p2w_pkg::*;
#(
   parameter int MAX_BYTES = 8,
   parameter int BC_W      = 4
) (
   input  logic                   rd,
   input  logic                   hdr,
   input  logic [7:0]             addr,
   input  logic [MAX_BYTES*8-1:0] wdata,
   input  logic [BC_W-1:0]        bcnt,
   input  logic [POS_W-1:0]       pos,
   output logic                   bit_val,
   output logic                   bit_rx
);
   logic [7:0] lane [MAX_BYTES+1];
   logic [7:0] cur;

   assign lane[0] = addr;
   for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
      assign lane[g+1] = wdata[g*8 +: 8];
   end

   always_comb begin
      cur = lane[bcnt];
      if (hdr) begin
         bit_val = rd;
      end else if (pos == PAR_POS) begin
         bit_val = odd_par(cur);
      end else begin
         bit_val = cur[~pos[2:0]];
      end
   end

   assign bit_rx = !hdr && rd && (bcnt != '0);

endmodule

// File: rtl/p2w_rxcap.sv
module p2w_rxcap
   import p2w_pkg::*;
#(
   parameter int MAX_BYTES = 8,
   parameter int BC_W      = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   smp,
   input  logic                   sda,
   input  logic [BC_W-1:0]        bcnt,
   input  logic [POS_W-1:0]       pos,
   output logic [MAX_BYTES*8-1:0] rdata,
   output logic                   perr
);
   logic [7:0] sh;
   logic       par_slot;

   assign par_slot = smp && (pos == PAR_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         perr <= 1'b0;
      end else begin
         if (clr) begin
            perr <= 1'b0;
         end else if (par_slot && (sda != odd_par(sh))) begin
            perr <= 1'b1;
         end
         if (smp && !par_slot) begin
            sh <= {sh[6:0], sda};
         end
      end
   end

   for (genvar g = 0; g < MAX_BYTES; g++) begin : g_store
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (par_slot && (bcnt == BC_W'(g + 1))) begin
            q <= sh;
         end
      end
      assign rdata[g*8 +: 8] = q;
   end

endmodule

// File: rtl/p2w_engine.sv
module p2w_engine
   import p2w_pkg::*;
#(
   parameter int  MAX_BYTES = 8,
   parameter int  DIV_W     = 8,
   parameter int  DLY_W     = 3,
   localparam int LEN_W     = $clog2(MAX_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic                   rd_i,
   input  logic [LEN_W-1:0]       len_i,
   input  logic [7:0]             addr_i,
   input  logic [MAX_BYTES*8-1:0] wdata_i,
   input  logic [DIV_W-1:0]       div_i,
   input  logic [DLY_W-1:0]       dly_i,
   input  logic                   sda_i,
   output logic                   scl_o,
   output logic                   sda_o,
   output logic                   sda_oe_o,
   output logic                   busy_o,
   output logic                   done_o,
   output logic                   err_o,
   output logic [MAX_BYTES*8-1:0] rdata_o
);
   localparam int BC_W = LEN_W + 1;

   if (MAX_BYTES < 2 || (MAX_BYTES & (MAX_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("MAX_BYTES must be a power of two of at least 2");
   end
   if (DIV_W < 2 || DLY_W < 1 || DLY_W > DIV_W) begin : g_bad_timing
      $error("DIV_W must be at least 2 and DLY_W must lie in 1..DIV_W");
   end

   p2w_state_e             state;
   logic                   rd_q;
   logic [LEN_W-1:0]       len_q;
   logic [7:0]             addr_q;
   logic [MAX_BYTES*8-1:0] wdata_q;
   logic [DIV_W-1:0]       div_q;
   logic [DLY_W-1:0]       dly_q;
   logic [BC_W-1:0]        bcnt;
   logic [POS_W-1:0]       pos;
   logic                   hdr;
   logic                   scl_q, sda_q, oe_q, done_q, err_q;

   logic                   run, half_end, drv_pt;
   logic                   bit_val, bit_rx, perr, smp, clr;
   logic [BC_W-1:0]        last_b;

   assign run    = (state != ST_IDLE);
   assign last_b = BC_W'(len_q) + BC_W'(1);
   assign smp    = (state == ST_BIT_LO) && half_end && bit_rx;
   assign clr    = (state == ST_IDLE) && start_i;

   p2w_halftimer #(.DIV_W(DIV_W), .DLY_W(DLY_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .div      (div_q),
      .dly      (dly_q),
      .half_end (half_end),
      .drv_pt   (drv_pt)
   );

   p2w_bitsrc #(.MAX_BYTES(MAX_BYTES), .BC_W(BC_W)) i_bitsrc (
      .rd      (rd_q),
      .hdr     (hdr),
      .addr    (addr_q),
      .wdata   (wdata_q),
      .bcnt    (bcnt),
      .pos     (pos),
      .bit_val (bit_val),
      .bit_rx  (bit_rx)
   );

   p2w_rxcap #(.MAX_BYTES(MAX_BYTES), .BC_W(BC_W)) i_rxcap (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .smp   (smp),
      .sda   (sda_i),
      .bcnt  (bcnt),
      .pos   (pos),
      .rdata (rdata_o),
      .perr  (perr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         rd_q    <= 1'b0;
         len_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         div_q   <= '0;
         dly_q   <= '0;
         bcnt    <= '0;
         pos     <= '0;
         hdr     <= 1'b0;
         scl_q   <= 1'b1;
         sda_q   <= 1'b1;
         oe_q    <= 1'b1;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  rd_q    <= rd_i;
                  len_q   <= len_i;
                  addr_q  <= addr_i;
                  wdata_q <= wdata_i;
                  div_q   <= div_i;
                  dly_q   <= dly_i;
                  bcnt    <= '0;
                  pos     <= '0;
                  hdr     <= 1'b1;
                  sda_q   <= 1'b0;
                  oe_q    <= 1'b1;
                  state   <= ST_START;
               end
            end
            ST_START: begin
               if (half_end) begin
                  scl_q <= 1'b0;
                  state <= ST_BIT_LO;
               end
            end
            ST_BIT_LO: begin
               if (drv_pt) begin
                  if (bit_rx) begin
                     oe_q  <= 1'b0;
                     sda_q <= 1'b1;
                  end else begin
                     oe_q  <= 1'b1;
                     sda_q <= bit_val;
                  end
               end
               if (half_end) begin
                  scl_q <= 1'b1;
                  state <= ST_BIT_HI;
               end
            end
            ST_BIT_HI: begin
               if (half_end) begin
                  scl_q <= 1'b0;
                  state <= ST_BIT_LO;
                  if (hdr) begin
                     hdr <= 1'b0;
                  end else if (pos == PAR_POS) begin
                     if (bcnt == last_b) begin
                        state <= ST_STOP_LO;
                     end else begin
                        bcnt <= bcnt + BC_W'(1);
                        pos  <= '0;
                     end
                  end else begin
                     pos <= pos + POS_W'(1);
                  end
               end
            end
            ST_STOP_LO: begin
               if (drv_pt) begin
                  oe_q  <= 1'b1;
                  sda_q <= 1'b0;
               end
               if (half_end) begin
                  scl_q <= 1'b1;
                  state <= ST_STOP_HI;
               end
            end
            ST_STOP_HI: begin
               if (half_end) begin
                  sda_q  <= 1'b1;
                  done_q <= 1'b1;
                  err_q  <= perr;
                  state  <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign scl_o    = scl_q;
   assign sda_o    = sda_q;
   assign sda_oe_o = oe_q;
   assign busy_o   = run;
   assign done_o   = done_q;
   assign err_o    = err_q;

endmodule

// File: rtl/p2w_engine_chk.sv
module p2w_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic scl_o,
   input logic sda_o,
   input logic sda_oe_o,
   input logic busy_o,
   input logic done_o,
   input logic err_o
);

   AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (scl_o && sda_o && sda_oe_o)); // R1

   AST_START_CONDITION: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !$past(busy_o)) |-> (scl_o && !sda_o)); // R2

   AST_STOP_CONDITION: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (scl_o && sda_o && $past(scl_o) && !$past(sda_o) && $past(busy_o))); // R2

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R2

   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o); // R6

   AST_RELEASE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !sda_oe_o |-> busy_o); // R5

   AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && scl_o && $past(scl_o))
         |-> ($stable(sda_o) && $stable(sda_oe_o))); // R8

   AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o); // R9

endmodule

bind p2w_engine p2w_engine_chk i_chk (.*);

// File: tb/test_p2w_engine.sv
module test_p2w_engine;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i, rd_i, sda_i;
   logic [2:0]  len_i;
   logic [7:0]  addr_i;
   logic [63:0] wdata_i;
   logic [7:0]  div_i;
   logic [2:0]  dly_i;
   logic        scl_o, sda_o, sda_oe_o, busy_o, done_o, err_o;
   logic [63:0] rdata_o;

   int n_chk = 0;
   int n_bad = 0;

   // parameters of the frame to chain on completion
   logic        nx_rd;
   int          nx_cnt, nx_div, nx_dly;
   logic [7:0]  nx_addr;
   logic [63:0] nx_wd;

   always #(CLK_PERIOD/2) clk = ~clk;

   p2w_engine i_p2w_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i), .len_i(len_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .div_i(div_i), .dly_i(dly_i),
      .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o), .sda_oe_o(sda_oe_o),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic oddp(input logic [7:0] b);
      return ~^b;
   endfunction

   task automatic xfer(input string name, input bit rd, input int cnt,
                       input logic [7:0] addr, input logic [63:0] wd,
                       input int div, input int dly, input logic [63:0] rxd,
                       input logic [7:0] bad_mask, input bit prestarted,
                       input bit chain, input bit glitch);
      int dive, dlye, t, nb, nexp, fall_t, hi_cnt, lo_cnt;
      int bad_hi, bad_lo, bad_dly, bad_hold, mism;
      bit pend, stop_seen, done_seen, err_seen, exp_err;
      logic prev_scl, prev_busy, line;
      logic [1:0] prev_drv;
      logic [0:95] seen, expb;

      dive = (div < 2) ? 2 : div;
      dlye = (dly < 1) ? 1 : dly;
      if (dlye > dive - 1) dlye = dive - 1;

      if (!prestarted) begin
         rd_i = rd; len_i = 3'(cnt - 1); addr_i = addr; wdata_i = wd;
         div_i = 8'(div); dly_i = 3'(dly); start_i = 1'b1;
      end
      sda_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, prestarted ? "R10" : "R9", {name, " busy after start"}, busy_o, 1);
      chk(scl_o == 1'b1 && sda_o == 1'b0, "R2", {name, " start condition"}, {scl_o, sda_o}, 2'b10);
      // scramble inputs: captured copy must govern the frame (R9)
      rd_i = ~rd; addr_i = ~addr; wdata_i = ~wd; len_i = ~len_i;

      // expected bit stream
      expb = '0;
      expb[0] = rd;
      for (int i = 0; i < 8; i++) expb[1+i] = addr[7-i];
      expb[9] = oddp(addr);
      for (int k = 0; k < cnt; k++) begin
         for (int p = 0; p < 8; p++)
            expb[10+9*k+p] = rd ? rxd[k*8+7-p] : wd[k*8+7-p];
         expb[10+9*k+8] = rd ? (oddp(rxd[k*8 +: 8]) ^ bad_mask[k]) : oddp(wd[k*8 +: 8]);
      end
      nexp = 10 + 9*cnt;
      exp_err = 1'b0;
      for (int k = 0; k < cnt; k++) if (rd && bad_mask[k]) exp_err = 1'b1;

      prev_scl = scl_o; prev_busy = busy_o; prev_drv = {sda_o, sda_oe_o};
      t = 0; nb = 0; fall_t = 0; hi_cnt = 1; lo_cnt = 0; seen = '0;
      bad_hi = 0; bad_lo = 0; bad_dly = 0; bad_hold = 0; pend = 1'b0;
      stop_seen = 1'b0; done_seen = 1'b0; err_seen = 1'b0;

      while (!done_seen && t < 60000) begin
         @(negedge clk);
         t++;
         if (glitch && t == 20) begin start_i = 1'b1; addr_i = 8'h00; rd_i = 1'b1; end
         if (glitch && t == 21) start_i = 1'b0;
         line = sda_oe_o ? sda_o : sda_i;
         if (scl_o && prev_scl) hi_cnt++;
         if (!scl_o && !prev_scl) lo_cnt++;
         if (!prev_scl && scl_o) begin
            if (lo_cnt != dive) bad_lo++;
            hi_cnt = 1;
            if (nb < 96) seen[nb] = line;
            nb++;
         end
         if (prev_scl && !scl_o) begin
            if (hi_cnt != dive) bad_hi++;
            lo_cnt = 1; fall_t = t; pend = 1'b1;
            if (rd && nb >= 10 && ((nb - 10) / 9) < cnt) begin
               int j, k, p;
               j = nb - 10; k = j / 9; p = j % 9;
               sda_i = (p < 8) ? rxd[k*8+7-p] : (oddp(rxd[k*8 +: 8]) ^ bad_mask[k]);
            end else begin
               sda_i = 1'b1;
            end
         end
         if ({sda_o, sda_oe_o} != prev_drv) begin
            if (busy_o && prev_busy && scl_o && prev_scl) bad_hold++;
            else if (busy_o && !scl_o) begin
               if (!pend || (t - fall_t) != dlye) bad_dly++;
               pend = 1'b0;
            end
         end
         if (prev_scl && scl_o && !prev_drv[1] && sda_o && !busy_o) stop_seen = 1'b1;
         if (done_o) begin
            done_seen = 1'b1;
            err_seen  = err_o;
            chk(!busy_o && scl_o && sda_o && sda_oe_o, "R1", {name, " lines idle at done"},
                {busy_o, scl_o, sda_o, sda_oe_o}, 4'b0111);
            if (chain) begin
               rd_i = nx_rd; len_i = 3'(nx_cnt - 1); addr_i = nx_addr; wdata_i = nx_wd;
               div_i = 8'(nx_div); dly_i = 3'(nx_dly); start_i = 1'b1;
            end
         end
         prev_scl = scl_o; prev_busy = busy_o; prev_drv = {sda_o, sda_oe_o};
      end

      chk(done_seen, "R2", {name, " done pulse"}, done_seen, 1);
      chk(stop_seen, "R2", {name, " stop condition"}, stop_seen, 1);
      chk(nb == nexp + 1, "R4", {name, " bit slot count"}, nb, nexp + 1);
      mism = 0;
      for (int i = 0; i < 10; i++) if (seen[i] !== expb[i]) mism++;
      chk(mism == 0, "R3", {name, " header bits"}, seen[0:9], expb[0:9]);
      mism = 0;
      for (int i = 10; i < nexp; i++) if (seen[i] !== expb[i]) mism++;
      chk(mism == 0, rd ? "R5" : "R4", {name, " data bit mismatches"}, mism, 0);
      if (rd) begin
         mism = 0;
         for (int k = 0; k < cnt; k++) if (rdata_o[k*8 +: 8] !== rxd[k*8 +: 8]) mism++;
         chk(mism == 0, "R5", {name, " read data"}, rdata_o, rxd);
      end
      chk(err_seen == exp_err, "R6", {name, " parity error flag"}, err_seen, exp_err);
      chk(bad_hi == 0 && bad_lo == 0, "R7", {name, " SCL phase length errors"}, bad_hi + bad_lo, 0);
      chk(bad_dly == 0, "R8", {name, " SDA delay errors"}, bad_dly, 0);
      chk(bad_hold == 0, "R8", {name, " SDA moved with SCL high"}, bad_hold, 0);
   endtask

   task automatic test_reset();
      chk(scl_o && sda_o && sda_oe_o, "R1", "reset lines", {scl_o, sda_o, sda_oe_o}, 3'b111);
      chk(!busy_o && !done_o && !err_o, "R1", "reset status", {busy_o, done_o, err_o}, 3'b000);
      chk(rdata_o == 64'h0, "R1", "reset rdata", rdata_o, 0);
   endtask

   task automatic test_write_one();
      xfer("wr1", 1'b0, 1, 8'hA5, 64'h3C, 4, 1, 64'h0, 8'h00, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic test_write_full();
      xfer("wr8", 1'b0, 8, 8'h00, 64'h0123_4567_89AB_CDEF, 3, 2, 64'h0, 8'h00, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic test_read_one();
      xfer("rd1", 1'b1, 1, 8'h7E, 64'h0, 5, 3, 64'h96, 8'h00, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic test_read_parity_err();
      xfer("rd4perr", 1'b1, 4, 8'h3B, 64'h0, 2, 0, 64'hDEAD_BEEF, 8'h04, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic test_clamps();
      // divider 0 acts as 2, delay 7 limited to 1 (R7, R8)
      xfer("clamp", 1'b0, 2, 8'hFF, 64'h8001, 0, 7, 64'h0, 8'h00, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic test_start_while_busy();
      // stray start mid-frame must be ignored (R9)
      xfer("glitch", 1'b0, 3, 8'h12, 64'hC0FFEE, 6, 4, 64'h0, 8'h00, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      chk(!busy_o, "R9", "no extra frame after stray start", busy_o, 0);
   endtask

   task automatic test_back_to_back();
      // start in the done cycle is taken (R10)
      nx_rd = 1'b0; nx_cnt = 1; nx_addr = 8'h81; nx_wd = 64'h18; nx_div = 4; nx_dly = 5;
      xfer("chainA", 1'b1, 2, 8'h40, 64'h0, 3, 1, 64'h55AA, 8'h00, 1'b0, 1'b1, 1'b0);
      xfer("chainB", 1'b0, 1, 8'h81, 64'h18, 4, 5, 64'h0, 8'h00, 1'b1, 1'b0, 1'b0);
      chk(rdata_o[15:0] == 16'h55AA, "R5", "read data kept after write", rdata_o[15:0], 16'h55AA);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_bad++;
      $display("FAIL R9 watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start_i = 1'b0; rd_i = 1'b0; len_i = '0; addr_i = '0;
      wdata_i = '0; div_i = '0; dly_i = '0; sda_i = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_write_one();
      test_write_full();
      test_read_one();
      test_read_parity_err();
      test_clamps();
      test_start_while_busy();
      test_back_to_back();
      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule